// File: doc/BRIEF.md
# NAND Flash Command and Address Sequencer

This block puts a single command onto a raw large-page NAND flash bus. The host gives an opcode, a block number, a page number and a column offset, and pulses `start`. The block waits until the flash reports ready. It then sends the opcode with the command latch high, the column and row address bytes with the address latch high, and, for the commands that need one, a second confirm opcode. Each strobe is a fixed number of clock cycles with write enable low, followed by the same number with it high.

How a command ends depends on its opcode. Reset, normal read and any opcode the block does not list run a guard delay of a fixed number of cycles after the bus phase, then wait for ready. Random data output and the program, erase, data-input and status opcodes end as soon as their last bus cycle has finished. Two requests are rewritten before they reach the bus. An out-of-band read goes out as a normal read with its column moved past the page data. On a 16-bit flash bus the column is given as a word offset.

A ready wait that runs too long ends the command with an error flag instead of hanging. The flag stays set until the next command is accepted.

Top module: `nand_cmd_seq`

## Requirements
- R1: After a command is accepted, no write strobe and no latch enable is driven until `nand_rb_n` is sampled high (1 = ready).
- R2: A bus cycle holds `nand_we_n` low for STROBE_CYC clocks and then high for STROBE_CYC clocks, with `nand_io_out` stable for the whole cycle. During it exactly one of `nand_cle` and `nand_ale` is high and `nand_ce_n` is low. When idle, all strobes and latches are inactive.
- R3: Opcode 0x50 (out-of-band read) is sent as opcode 0x00, with PAGE_BYTES added to the column and the 0x30 confirm.
- R4: With BUS16=1 the column is shifted right by one bit, except for the 8-bit-only opcodes 0x90, 0xEC, 0xEE and 0xEF.
- R5: The column goes out as two address cycles: bits 7:0 first, then bits 15:8.
- R6: The row is page + block × PAGES_PER_BLOCK. It is sent after the column as bits 7:0, then bits 15:8, then, with FIVE_CYCLE=1, a byte of 0000 followed by bits 19:16.
- R7: Opcode 0x05 (random data output) sends the command and the two column cycles, no row cycles, then the 0xE0 confirm. It finishes without a guard or a ready wait.
- R8: Opcode 0x00 (read) ends with the 0x30 confirm. It then waits GUARD_CYC = ceil(GUARD_NS / CLK_PERIOD_NS) clocks without looking at `nand_rb_n`, and raises `done` on the clock after `nand_rb_n` is seen high. Any opcode that is not listed in R7, R9 or R10 ends the same way, without a confirm.
- R9: Opcode 0xFF (reset) sends only its command cycle, then runs the guard and the ready wait.
- R10: Opcodes 0x10, 0x15, 0x60, 0xD0, 0x80, 0x85 and 0x70 raise `done` STROBE_CYC clocks after the write-enable rise of their last address cycle, whatever the level of `nand_rb_n`.
- R11: `busy` is high from the clock after acceptance through the `done` cycle. `done` is a single-cycle pulse, and `start` is ignored while `busy` is high.
- R12: If `nand_rb_n` stays low for TIMEOUT_CYC clocks of a ready wait, the command ends with `done` and `timeout_err` set. `timeout_err` stays set until the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted when idle |
| cmd | input | 8 | Command opcode |
| block | input | BLOCK_W | Erase-block number |
| page | input | $clog2(PAGES_PER_BLOCK) | Page within the block |
| column | input | 16 | Byte offset within the page |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| timeout_err | output | 1 | Last command ended on a ready timeout |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_io_out | output | 8 | Byte driven onto the flash I/O bus |
| nand_io_oe | output | 1 | Output enable for the I/O bus |
| nand_rb_n | input | 1 | Ready/busy from the flash, high = ready |

## Verification
The bench builds the block with BUS16=1, FIVE_CYCLE=1, a 5 ns clock period and a 150 ns guard (30 cycles), two-clock strobes and TIMEOUT_CYC=200. The 16-bit setting means the column shift and its 8-bit-opcode exception both show up in the byte stream. A block number of 9000 reaches row bits 19:16. The short timeout lets both ready waits, before and after the bus phase, run to expiry.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam logic [7:0] OPC_READ      = 8'h00;
  localparam logic [7:0] OPC_READ_GO   = 8'h30;
  localparam logic [7:0] OPC_OOB       = 8'h50;
  localparam logic [7:0] OPC_RND_OUT   = 8'h05;
  localparam logic [7:0] OPC_RND_GO    = 8'hE0;
  localparam logic [7:0] OPC_RESET     = 8'hFF;
  localparam logic [7:0] OPC_STATUS    = 8'h70;
  localparam logic [7:0] OPC_SEQ_IN    = 8'h80;
  localparam logic [7:0] OPC_RND_IN    = 8'h85;
  localparam logic [7:0] OPC_PROG      = 8'h10;
  localparam logic [7:0] OPC_CPROG     = 8'h15;
  localparam logic [7:0] OPC_ERASE_A   = 8'h60;
  localparam logic [7:0] OPC_ERASE_B   = 8'hD0;

  typedef enum logic [2:0] {
    ST_CMD, ST_COL0, ST_COL1, ST_ROW0, ST_ROW1, ST_ROW2, ST_CONF, ST_END
  } step_e;

  typedef enum logic [2:0] {
    FS_IDLE, FS_WAIT_IN, FS_BUS, FS_GUARD, FS_WAIT_OUT, FS_DONE
  } fsm_e;

  // R4: opcodes whose column is never converted to a word offset
  function automatic logic byte_only_op(input logic [7:0] op);
    return (op == 8'h90) || (op == 8'hEC) || (op == 8'hEE) || (op == 8'hEF);
  endfunction

  // R10: opcodes that end right after their address phase
  function automatic logic quick_finish(input logic [7:0] op);
    return (op == OPC_PROG) || (op == OPC_CPROG) || (op == OPC_ERASE_A) ||
           (op == OPC_ERASE_B) || (op == OPC_SEQ_IN) || (op == OPC_RND_IN) ||
           (op == OPC_STATUS);
  endfunction

  // R3: out-of-band read goes out as a plain read
  function automatic logic [7:0] issued_opcode(input logic [7:0] op);
    return (op == OPC_OOB) ? OPC_READ : op;
  endfunction

  // R3, R4: column after spare-area offset and bus-width scaling
  function automatic logic [15:0] column_bytes(input logic [7:0] op,
                                               input logic [15:0] col,
                                               input int page_bytes,
                                               input logic wide);
    logic [15:0] c;
    c = col;
    if (op == OPC_OOB) c = c + 16'(page_bytes);
    if (wide && !byte_only_op(issued_opcode(op))) c = c >> 1;
    return c;
  endfunction

  // R6: linear page index
  function automatic logic [23:0] row_index(input logic [23:0] blk,
                                            input logic [23:0] pg,
                                            input int ppb);
    return pg + blk * 24'(ppb);
  endfunction

  function automatic logic has_confirm(input logic [7:0] op);
    return (op == OPC_READ) || (op == OPC_RND_OUT);
  endfunction

  function automatic logic [7:0] confirm_code(input logic [7:0] op);
    return (op == OPC_RND_OUT) ? OPC_RND_GO : OPC_READ_GO;
  endfunction

  // R7, R8, R9, R10: does the command need the guard and the ready poll
  function automatic logic tail_waits(input logic [7:0] op);
    return !(quick_finish(op) || (op == OPC_RND_OUT));
  endfunction

  // Bus cycle order per opcode (R5, R6, R7, R9)
  function automatic step_e step_after(input step_e s, input logic [7:0] op,
                                       input logic five);
    case (s)
      ST_CMD:  return (op == OPC_RESET) ? ST_END : ST_COL0;
      ST_COL0: return ST_COL1;
      ST_COL1: return (op == OPC_RND_OUT) ? ST_CONF : ST_ROW0;
      ST_ROW0: return ST_ROW1;
      ST_ROW1: return five ? ST_ROW2 : (has_confirm(op) ? ST_CONF : ST_END);
      ST_ROW2: return has_confirm(op) ? ST_CONF : ST_END;
      default: return ST_END;
    endcase
  endfunction

  function automatic logic [7:0] bus_byte(input step_e s, input logic [7:0] op,
                                          input logic [15:0] col,
                                          input logic [23:0] row);
    case (s)
      ST_CMD:  return op;
      ST_COL0: return col[7:0];
      ST_COL1: return col[15:8];
      ST_ROW0: return row[7:0];
      ST_ROW1: return row[15:8];
      ST_ROW2: return {4'h0, row[19:16]};
      ST_CONF: return confirm_code(op);
      default: return 8'h00;
    endcase
  endfunction

  // R8: guard length in clocks, rounded up, at least one
  function automatic int guard_cycles(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/nand_cdown.sv
module nand_cdown #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign count = cnt_q;
  assign zero  = (cnt_q == '0);

  // R8: once expired, the timer stays parked until reloaded
  assert_cdown_parks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero);

endmodule

// File: rtl/nand_rdy_watch.sv
module nand_rdy_watch #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic rb_n,
  output logic ready,
  output logic expired
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] low_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         low_cnt_q <= '0;
    else if (!arm)                      low_cnt_q <= '0;
    else if (!rb_n && low_cnt_q != LIM) low_cnt_q <= low_cnt_q + 1'b1;
  end

  assign ready   = arm && rb_n;
  assign expired = arm && !rb_n && (low_cnt_q == LIM);

  // R12: each wait starts its count from zero
  assert_watch_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> (low_cnt_q == '0));

  // R12: expiry only follows a low ready/busy sample
  assert_expiry_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    expired |-> $past(!rb_n));

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int CLK_PERIOD_NS   = 5,
  parameter int GUARD_NS        = 150,
  parameter int STROBE_CYC      = 2,
  parameter int PAGE_BYTES      = 2048,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int BLOCK_W         = 14,
  parameter int TIMEOUT_CYC     = 100000,
  parameter bit BUS16           = 1'b0,
  parameter bit FIVE_CYCLE      = 1'b1,
  localparam int PAGE_W         = $clog2(PAGES_PER_BLOCK)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [7:0]         cmd,
  input  logic [BLOCK_W-1:0] block,
  input  logic [PAGE_W-1:0]  page,
  input  logic [15:0]        column,
  output logic               busy,
  output logic               done,
  output logic               timeout_err,
  output logic               nand_ce_n,
  output logic               nand_cle,
  output logic               nand_ale,
  output logic               nand_we_n,
  output logic [7:0]         nand_io_out,
  output logic               nand_io_oe,
  input  logic               nand_rb_n
);

  localparam int GUARD_CYC  = guard_cycles(GUARD_NS, CLK_PERIOD_NS);
  localparam int STROBE_TOP = 2 * STROBE_CYC - 1;
  localparam int GUARD_TOP  = GUARD_CYC - 1;
  localparam int TMR_TOP    = (STROBE_TOP > GUARD_TOP) ? STROBE_TOP : GUARD_TOP;
  localparam int TMR_W      = (TMR_TOP < 1) ? 1 : $clog2(TMR_TOP + 1);

  fsm_e        fsm_q;
  step_e       step_q;
  logic [7:0]  op_q;
  logic [15:0] col_q;
  logic [23:0] row_q;
  logic        err_q;

  // named internal events
  logic             accept;
  logic             in_bus;
  logic             bus_end;
  step_e            step_nx;
  logic             load_strobe;
  logic             load_guard;
  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic [TMR_W-1:0] tmr_cnt;
  logic             tmr_zero;
  logic             rdy_arm;
  logic             rdy_ok;
  logic             rdy_expired;
  logic             strobe_low;

  assign accept  = start && (fsm_q == FS_IDLE);
  assign in_bus  = (fsm_q == FS_BUS);
  assign bus_end = in_bus && tmr_zero;
  assign step_nx = step_after(step_q, op_q, FIVE_CYCLE);

  assign load_strobe = ((fsm_q == FS_WAIT_IN) && nand_rb_n) ||
                       (bus_end && (step_nx != ST_END));
  assign load_guard  = bus_end && (step_nx == ST_END) && tail_waits(op_q);
  assign tmr_load    = load_strobe || load_guard;
  assign tmr_val     = load_guard ? TMR_W'(GUARD_TOP) : TMR_W'(STROBE_TOP);
  assign rdy_arm     = (fsm_q == FS_WAIT_IN) || (fsm_q == FS_WAIT_OUT);
  assign strobe_low  = tmr_cnt >= TMR_W'(STROBE_CYC);

  nand_cdown #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .count    (tmr_cnt),
    .zero     (tmr_zero)
  );

  nand_rdy_watch #(.LIMIT(TIMEOUT_CYC)) u_watch (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (rdy_arm),
    .rb_n    (nand_rb_n),
    .ready   (rdy_ok),
    .expired (rdy_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q  <= FS_IDLE;
      step_q <= ST_CMD;
      op_q   <= '0;
      col_q  <= '0;
      row_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      case (fsm_q)
        FS_IDLE: if (accept) begin
          fsm_q <= FS_WAIT_IN;
          op_q  <= issued_opcode(cmd);
          col_q <= column_bytes(cmd, column, PAGE_BYTES, BUS16);
          row_q <= row_index(24'(block), 24'(page), PAGES_PER_BLOCK);
          err_q <= 1'b0;
        end
        FS_WAIT_IN: begin
          if (rdy_ok) begin
            fsm_q  <= FS_BUS;
            step_q <= ST_CMD;
          end else if (rdy_expired) begin
            fsm_q <= FS_DONE;
            err_q <= 1'b1;
          end
        end
        FS_BUS: if (bus_end) begin
          if (step_nx == ST_END) fsm_q <= tail_waits(op_q) ? FS_GUARD : FS_DONE;
          else                   step_q <= step_nx;
        end
        FS_GUARD: if (tmr_zero) fsm_q <= FS_WAIT_OUT;
        FS_WAIT_OUT: begin
          if (rdy_ok) begin
            fsm_q <= FS_DONE;
          end else if (rdy_expired) begin
            fsm_q <= FS_DONE;
            err_q <= 1'b1;
          end
        end
        default: fsm_q <= FS_IDLE;
      endcase
    end
  end

  always_comb begin
    busy        = (fsm_q != FS_IDLE);
    done        = (fsm_q == FS_DONE);
    timeout_err = err_q;
    nand_ce_n   = !busy;
    nand_io_oe  = in_bus;
    nand_we_n   = !(in_bus && strobe_low);
    nand_cle    = in_bus && ((step_q == ST_CMD) || (step_q == ST_CONF));
    nand_ale    = in_bus && (step_q inside {ST_COL0, ST_COL1, ST_ROW0, ST_ROW1, ST_ROW2});
    nand_io_out = in_bus ? bus_byte(step_q, op_q, col_q, row_q) : 8'h00;
  end

  assert_one_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> (nand_cle ^ nand_ale));

  assert_ce_on_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> !nand_ce_n);

  assert_data_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bus && !tmr_zero) |=> $stable(nand_io_out));

  assert_ready_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_io_oe) |-> $past(nand_rb_n));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_err_on_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> $past(!nand_rb_n));

endmodule

// File: tb/nand_cmd_seq_tb.sv
module nand_cmd_seq_tb;

  localparam int S = 2;
  localparam int G = 30;
  localparam int T = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  cmd = 8'h00;
  logic [13:0] block = '0;
  logic [5:0]  page = '0;
  logic [15:0] column = '0;
  logic        nand_rb_n = 1'b1;
  logic        busy, done, timeout_err;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_io_oe;
  logic [7:0]  nand_io_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rise_cnt = 0;
  int rise_cyc = 0;
  int low_len = 0;
  logic prev_we = 1'b1;
  logic [9:0] expq[$];

  always #2.5 clk = ~clk;

  nand_cmd_seq #(
    .CLK_PERIOD_NS(5), .GUARD_NS(150), .STROBE_CYC(S), .PAGE_BYTES(2048),
    .PAGES_PER_BLOCK(64), .BLOCK_W(14), .TIMEOUT_CYC(T),
    .BUS16(1'b1), .FIVE_CYCLE(1'b1)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .block(block),
    .page(page), .column(column), .busy(busy), .done(done),
    .timeout_err(timeout_err), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_io_out(nand_io_out),
    .nand_io_oe(nand_io_oe), .nand_rb_n(nand_rb_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: one scoreboard pop per completed write strobe
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!nand_we_n) low_len++;
      else if (!prev_we) begin
        rise_cnt++;
        rise_cyc = cyc;
        check(low_len == S, "R2 strobe low width", low_len, S);
        if (expq.size() == 0) begin
          check(1'b0, "R11 unexpected bus cycle", {nand_cle, nand_ale, nand_io_out}, 0);
        end else begin
          logic [9:0] e;
          e = expq.pop_front();
          check({nand_cle, nand_ale, nand_io_out} == e, "R2/R5/R6 bus cycle",
                {nand_cle, nand_ale, nand_io_out}, e);
        end
        low_len = 0;
      end
    end
    prev_we = nand_we_n;
  end

  // driver side: expected byte stream from the requirements
  task automatic plan(input logic [7:0] op, input int blk, input int pg,
                      input logic [15:0] col, output int n);
    logic [7:0]  iss;
    logic [15:0] c;
    int          row;
    n = 0;
    iss = (op == 8'h50) ? 8'h00 : op;                      // R3
    expq.push_back({2'b10, iss}); n++;
    if (op == 8'hFF) return;                                // R9
    c = col;
    if (op == 8'h50) c = c + 16'd2048;                      // R3
    if (!(iss == 8'h90 || iss == 8'hEC || iss == 8'hEE || iss == 8'hEF))
      c = {1'b0, c[15:1]};                                  // R4
    expq.push_back({2'b01, c[7:0]});  n++;                  // R5
    expq.push_back({2'b01, c[15:8]}); n++;
    if (iss != 8'h05) begin                                 // R7
      row = blk * 64 + pg;                                  // R6
      expq.push_back({2'b01, 8'(row)});        n++;
      expq.push_back({2'b01, 8'(row >> 8)});   n++;
      expq.push_back({2'b01, 4'h0, 4'(row >> 16)}); n++;
    end
    if (iss == 8'h00) begin expq.push_back({2'b10, 8'h30}); n++; end  // R8
    if (iss == 8'h05) begin expq.push_back({2'b10, 8'hE0}); n++; end  // R7
  endtask

  // mode 0: ready stays high; 1: quick finish, ready dropped after first strobe;
  // 2: ready low for 60 clocks after last strobe; 3: ready never returns;
  // 4: ready low at start for 20 clocks; 5: extra start while busy
  task automatic run_cmd(input logic [7:0] op, input int blk, input int pg,
                         input logic [15:0] col, input int mode, input string req);
    int n, base, last, rel, done_at, expect_at, waited;
    plan(op, blk, pg, col, n);
    base = rise_cnt; last = -1; rel = -1; done_at = -1; waited = 0;
    @(negedge clk); #1;
    if (mode == 4) nand_rb_n = 1'b0;
    cmd = op; block = 14'(blk); page = 6'(pg); column = col; start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    check(timeout_err == 1'b0, "R12 flag cleared on accept", timeout_err, 0);
    if (mode == 4) begin
      bit quiet;
      quiet = 1'b1;
      repeat (20) begin
        @(negedge clk); #1;
        if (!nand_we_n || nand_io_oe || nand_cle || nand_ale) quiet = 1'b0;
      end
      check(quiet, "R1 no bus activity while not ready", quiet, 1);
      nand_rb_n = 1'b1;
    end
    while (done_at < 0 && waited < 5000) begin
      @(negedge clk); #1;
      waited++;
      if (mode == 5 && waited == 4) begin cmd = 8'h70; start = 1'b1; end
      if (mode == 5 && waited == 5) start = 1'b0;
      if (mode == 1 && rise_cnt == base + 1) nand_rb_n = 1'b0;
      if (last < 0 && rise_cnt == base + n) begin
        last = rise_cyc;
        if (mode == 2 || mode == 3) nand_rb_n = 1'b0;
      end
      if (mode == 2 && last >= 0 && rel < 0 && cyc == last + 60) begin
        nand_rb_n = 1'b1; rel = cyc;
      end
      if (done) done_at = cyc;
    end
    case (mode)
      1:       expect_at = last + S;
      2:       expect_at = rel + 1;
      3:       expect_at = last + S + G + T + 1;
      default: expect_at = last + S + G + 1;
    endcase
    check(done_at == expect_at, req, done_at - last, expect_at - last);
    check(rise_cnt - base == n, "R11 bus cycle count", rise_cnt - base, n);
    check(timeout_err == (mode == 3), "R12 error flag at done", timeout_err, mode == 3);
    @(negedge clk); #1;
    check(!done && !busy, "R11 single done pulse", {done, busy}, 0);
    if (mode == 3) begin
      repeat (3) @(negedge clk);
      #1 check(timeout_err == 1'b1, "R12 flag held while idle", timeout_err, 1);
    end
    nand_rb_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): run did not end, actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base, c0, done_at, waited;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    check({busy, done, timeout_err, nand_we_n, nand_ce_n, nand_cle, nand_ale, nand_io_oe}
          == 8'b00011000, "R2 idle outputs after reset",
          {busy, done, timeout_err, nand_we_n, nand_ce_n, nand_cle, nand_ale, nand_io_oe},
          8'b00011000);

    run_cmd(8'h00, 9000, 17, 16'h0104, 0, "R8 read guard and ready latency");
    run_cmd(8'h50, 5, 3, 16'h0006, 0, "R3 out-of-band read latency");
    run_cmd(8'h90, 0, 0, 16'h0020, 0, "R4 byte-only opcode latency");
    run_cmd(8'h05, 1, 1, 16'h0200, 1, "R7 random out ends without wait");
    run_cmd(8'h10, 77, 9, 16'h0010, 1, "R10 program ends without wait");
    run_cmd(8'h60, 300, 0, 16'h0000, 1, "R10 erase setup ends without wait");
    run_cmd(8'h70, 2, 2, 16'h0002, 1, "R10 status ends without wait");
    run_cmd(8'h80, 16383, 63, 16'h07FE, 1, "R10 serial input ends without wait");
    run_cmd(8'hFF, 0, 0, 16'h0000, 0, "R9 reset guard and ready latency");
    run_cmd(8'hFF, 0, 0, 16'h0000, 2, "R9 reset waits for ready");
    run_cmd(8'h00, 12, 5, 16'h0040, 2, "R8 read waits for ready");
    run_cmd(8'h00, 40, 1, 16'h0000, 3, "R12 timeout after guard");
    run_cmd(8'h00, 3, 4, 16'h0100, 4, "R1 waits for ready before command");
    run_cmd(8'h00, 6, 6, 16'h0008, 5, "R11 start ignored while busy");

    // R12: timeout in the wait before the command phase, no bus cycles
    base = rise_cnt; done_at = -1; waited = 0;
    @(negedge clk); #1;
    nand_rb_n = 1'b0; cmd = 8'h00; start = 1'b1; c0 = cyc;
    @(negedge clk); #1;
    start = 1'b0;
    while (done_at < 0 && waited < 1000) begin
      @(negedge clk); #1;
      waited++;
      if (done) done_at = cyc;
    end
    check(done_at == c0 + T + 2, "R12 timeout before command", done_at - c0, T + 2);
    check(timeout_err == 1'b1, "R12 error on early timeout", timeout_err, 1);
    check(rise_cnt == base, "R1 no strobe without ready", rise_cnt - base, 0);
    nand_rb_n = 1'b1;
    repeat (2) @(negedge clk);
    check(expq.size() == 0, "R11 scoreboard drained", expq.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule